// File: doc/BRIEF.md
# Block-Transfer Device Interface with DMA Request

This block connects a byte-producing peripheral to a system bus on which a processor sees a few I/O ports and a DMA controller moves the data. Software first polls a status port until the busy flag reads zero. It then writes the command port with the direction and start bits set together (value 5 for an input block). The write sends a one-cycle start pulse to the peripheral, latches the direction and marks the interface busy.

While the interface is busy and the direction is input, each byte the peripheral presents is placed in a single-entry data buffer, and a DMA request is raised for it. The request stays high until the DMA controller's acknowledge is sampled, or until the buffer port is read on the bus. The request then falls for at least one cycle before the next byte can raise it again. A byte that arrives while the previous one is still pending is discarded, and a sticky overrun flag records the loss. The busy flag drops when the peripheral's remaining-byte count input reads zero.

Top module: `dev_dma_if`

## Requirements
- R1: After reset, the status port (offset 0) reads 0x00, and dmaReq and devStart are low.
- R2: A write to the command port (offset 1) stores wdata bit 0 as the direction (1 = input). The direction drives devDirIn and reads back in bit 0 of the command port.
- R3: Writing command bit 2 as 1 drives devStart high for exactly the one cycle after the write. Command bit 2 always reads back as 0.
- R4: Status bit 2 (busy) reads 1 from the cycle after a start write.
- R5: While busy and not being started, a devRemain value of 0 clears busy on the next clock edge.
- R6: A byte presented with devByteValid, while busy, in input direction and with no request pending, is loaded into the buffer. dmaReq rises in the next cycle and dmaData shows the byte.
- R7: dmaReq stays high until dmaAck is sampled high, and is low in the cycle after that.
- R8: A bus read of offset 2 returns the buffered byte and clears a pending request on that clock edge.
- R9: A byte arriving while a request is pending sets status bit 4 (overrun) and leaves the buffer unchanged.
- R10: A start write clears the overrun flag.
- R11: Bytes presented while not busy, or while the direction is output, change neither dmaReq nor the status.
- R12: Status bit 0 reads 1 exactly while a DMA request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioSel | input | 1 | Port access select |
| ioWr | input | 1 | Write strobe |
| ioRd | input | 1 | Read strobe |
| ioAddr | input | 2 | Port offset |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Read data, zero when no read is selected |
| devByteValid | input | 1 | Peripheral presents a byte this cycle |
| devByte | input | 8 | Peripheral byte |
| devRemain | input | 16 | Bytes left in the current block |
| devStart | output | 1 | One-cycle start pulse to the peripheral |
| devDirIn | output | 1 | Latched direction, 1 = input |
| dmaReq | output | 1 | DMA request |
| dmaAck | input | 1 | DMA acknowledge |
| dmaData | output | 8 | Buffered byte for the DMA controller |

## Verification
The assertions take for granted that ioWr and ioRd are never asserted in the same cycle, and that bus strobes are only meaningful when ioSel is high. They also take for granted that the DMA controller asserts dmaAck only while dmaReq is high. The stimulus drives every bus access as a single selected cycle with one strobe. The DMA side acknowledges only a request it has seen at the falling clock edge, and holds the acknowledge for one cycle. devRemain is set to a nonzero value before a block starts and held there until the bench ends the block on purpose, so the busy flag clears only when the bench intends it to.

// File: rtl/dev_dma_if_pkg.sv
package dev_dma_if_pkg;
  // status bit positions
  localparam int STAT_PEND_BIT = 0;
  localparam int STAT_BUSY_BIT = 2;
  localparam int STAT_OVR_BIT  = 4;
  // command bit positions
  localparam int CMD_DIR_BIT   = 0;
  localparam int CMD_START_BIT = 2;

  typedef struct packed {
    logic cmdWr;    // command port written
    logic bufLoad;  // capture peripheral byte
    logic bufRd;    // buffer port read on the bus
  } difStrobe_t;
endpackage

// File: rtl/dev_dma_if_ctrl.sv
module dev_dma_if_ctrl
  import dev_dma_if_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int CW = 16,
  parameter int CMD_OFS = 1,
  parameter int BUF_OFS = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ioSel,
  input  logic          ioWr,
  input  logic          ioRd,
  input  logic [AW-1:0] ioAddr,
  input  logic [DW-1:0] ioWdata,
  input  logic          devByteValid,
  input  logic [CW-1:0] devRemain,
  input  logic          dirIn,
  input  logic          dmaAck,
  output difStrobe_t    strb,
  output logic          startQ,
  output logic          busyQ,
  output logic          reqQ,
  output logic          ovrQ
);
  localparam logic [AW-1:0] CMD_A = AW'(CMD_OFS);
  localparam logic [AW-1:0] BUF_A = AW'(BUF_OFS);

  logic cmdHit, bufRdHit, startWr, byteEligible, accept, drop, reqClear, blockEnd;

  always_comb begin
    cmdHit       = ioSel && ioWr && (ioAddr == CMD_A);
    bufRdHit     = ioSel && ioRd && (ioAddr == BUF_A);
    startWr      = cmdHit && ioWdata[CMD_START_BIT];
    byteEligible = devByteValid && busyQ && dirIn;
    accept       = byteEligible && !reqQ;
    drop         = byteEligible && reqQ;
    reqClear     = reqQ && (dmaAck || bufRdHit);
    blockEnd     = busyQ && (devRemain == '0);
    strb.cmdWr   = cmdHit;
    strb.bufLoad = accept;
    strb.bufRd   = bufRdHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= 1'b0;
      busyQ  <= 1'b0;
      reqQ   <= 1'b0;
      ovrQ   <= 1'b0;
    end else begin
      startQ <= startWr;
      if (startWr)       busyQ <= 1'b1;
      else if (blockEnd) busyQ <= 1'b0;
      if (accept)        reqQ <= 1'b1;
      else if (reqClear) reqQ <= 1'b0;
      if (startWr)       ovrQ <= 1'b0;
      else if (drop)     ovrQ <= 1'b1;
    end
  end
endmodule

// File: rtl/dev_dma_if_dp.sv
module dev_dma_if_dp
  import dev_dma_if_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int STAT_OFS = 0,
  parameter int CMD_OFS = 1,
  parameter int BUF_OFS = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  difStrobe_t    strb,
  input  logic          ioSel,
  input  logic          ioRd,
  input  logic [AW-1:0] ioAddr,
  input  logic [DW-1:0] ioWdata,
  input  logic [DW-1:0] devByte,
  input  logic          busy,
  input  logic          pend,
  input  logic          ovr,
  output logic          dirIn,
  output logic [DW-1:0] bufQ,
  output logic [DW-1:0] ioRdata
);
  localparam logic [AW-1:0] STAT_A = AW'(STAT_OFS);
  localparam logic [AW-1:0] CMD_A  = AW'(CMD_OFS);
  localparam logic [AW-1:0] BUF_A  = AW'(BUF_OFS);

  logic [DW-1:0] statusByte, cmdByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirIn <= 1'b0;
      bufQ  <= '0;
    end else begin
      if (strb.cmdWr)   dirIn <= ioWdata[CMD_DIR_BIT];
      if (strb.bufLoad) bufQ  <= devByte;
    end
  end

  always_comb begin
    statusByte = '0;
    statusByte[STAT_PEND_BIT] = pend;
    statusByte[STAT_BUSY_BIT] = busy;
    statusByte[STAT_OVR_BIT]  = ovr;
    cmdByte = '0;
    cmdByte[CMD_DIR_BIT] = dirIn;  // start bit always reads 0
    ioRdata = '0;
    if (ioSel && ioRd) begin
      if (ioAddr == STAT_A)     ioRdata = statusByte;
      else if (ioAddr == CMD_A) ioRdata = cmdByte;
      else if (ioAddr == BUF_A) ioRdata = bufQ;
    end
  end
endmodule

// File: rtl/dev_dma_if.sv
module dev_dma_if
  import dev_dma_if_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int CW = 16,
  parameter int STAT_OFS = 0,
  parameter int CMD_OFS = 1,
  parameter int BUF_OFS = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ioSel,
  input  logic          ioWr,
  input  logic          ioRd,
  input  logic [AW-1:0] ioAddr,
  input  logic [DW-1:0] ioWdata,
  output logic [DW-1:0] ioRdata,
  input  logic          devByteValid,
  input  logic [DW-1:0] devByte,
  input  logic [CW-1:0] devRemain,
  output logic          devStart,
  output logic          devDirIn,
  output logic          dmaReq,
  input  logic          dmaAck,
  output logic [DW-1:0] dmaData
);
  difStrobe_t strb;
  logic startQ, busy, reqQ, ovr, dirIn;
  logic [DW-1:0] bufQ;

  dev_dma_if_ctrl #(.DW(DW), .AW(AW), .CW(CW), .CMD_OFS(CMD_OFS), .BUF_OFS(BUF_OFS)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioSel(ioSel), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
    .ioWdata(ioWdata), .devByteValid(devByteValid), .devRemain(devRemain), .dirIn(dirIn),
    .dmaAck(dmaAck), .strb(strb), .startQ(startQ), .busyQ(busy), .reqQ(reqQ), .ovrQ(ovr)
  );

  dev_dma_if_dp #(.DW(DW), .AW(AW), .STAT_OFS(STAT_OFS), .CMD_OFS(CMD_OFS), .BUF_OFS(BUF_OFS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioSel(ioSel), .ioRd(ioRd), .ioAddr(ioAddr),
    .ioWdata(ioWdata), .devByte(devByte), .busy(busy), .pend(reqQ), .ovr(ovr),
    .dirIn(dirIn), .bufQ(bufQ), .ioRdata(ioRdata)
  );

  assign devStart = startQ;
  assign devDirIn = dirIn;
  assign dmaReq   = reqQ;
  assign dmaData  = bufQ;
endmodule

// File: rtl/dev_dma_if_chk.sv
module dev_dma_if_chk #(
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int CMD_OFS = 1,
  parameter int BUF_OFS = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          ioSel,
  input logic          ioWr,
  input logic          ioRd,
  input logic [AW-1:0] ioAddr,
  input logic [DW-1:0] ioWdata,
  input logic          devByteValid,
  input logic [DW-1:0] dmaData,
  input logic          devStart,
  input logic          dmaReq,
  input logic          dmaAck,
  input logic          busy,
  input logic          ovr
);
  logic startW, bufRd;
  assign startW = ioSel && ioWr && (ioAddr == AW'(CMD_OFS)) && ioWdata[2];
  assign bufRd  = ioSel && ioRd && (ioAddr == AW'(BUF_OFS));

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) devStart |=> !devStart);
  // R3
  start_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN) startW |=> devStart);
  // R4
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rstN) startW |=> busy);
  // R7
  req_drop_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN) (dmaReq && dmaAck) |=> !dmaReq);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN) (dmaReq && !dmaAck && !bufRd) |=> dmaReq);
  // R9
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rstN) (dmaReq && !dmaAck && !bufRd) |=> $stable(dmaData));
  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN) (dmaReq && devByteValid && busy && !startW && !dmaAck && !bufRd) |=> ovr);
  // R10
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rstN) startW |=> !ovr);
endmodule

bind dev_dma_if dev_dma_if_chk #(.DW(DW), .AW(AW), .CMD_OFS(CMD_OFS), .BUF_OFS(BUF_OFS)) u_chk (
  .clk(clk), .rstN(rstN), .ioSel(ioSel), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
  .ioWdata(ioWdata), .devByteValid(devByteValid), .dmaData(dmaData), .devStart(devStart),
  .dmaReq(dmaReq), .dmaAck(dmaAck), .busy(busy), .ovr(ovr)
);

// File: tb/dev_dma_if_bench.sv
module dev_dma_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic clk = 0, rstN = 0;
  logic ioSel = 0, ioWr = 0, ioRd = 0;
  logic [1:0] ioAddr = 0;
  logic [7:0] ioWdata = 0, devByte = 0;
  logic [7:0] ioRdata, dmaData;
  logic devByteValid = 0;
  logic [15:0] devRemain = 0;
  logic devStart, devDirIn, dmaReq, dmaAck;
  logic monAck = 0, manAck = 0, monEn = 0;
  int checks = 0, failures = 0, cyc = 0;
  logic [7:0] expQ[$];

  assign dmaAck = monAck | manAck;

  always #(CLK_PERIOD/2) clk = ~clk;

  dev_dma_if u_dev_dma_if (
    .clk(clk), .rstN(rstN), .ioSel(ioSel), .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .devByteValid(devByteValid), .devByte(devByte),
    .devRemain(devRemain), .devStart(devStart), .devDirIn(devDirIn), .dmaReq(dmaReq),
    .dmaAck(dmaAck), .dmaData(dmaData)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      failures++;
      finishRun();
    end
  end

  // monitor: serve requests and compare against the scoreboard
  always @(negedge clk) begin
    if (monEn && dmaReq && !monAck) begin
      if (expQ.size() == 0) check("R6 unexpected request", dmaData, 8'h00);
      else check("R6 dma byte", dmaData, expQ.pop_front());
      monAck <= 1'b1;
    end else monAck <= 1'b0;
  end

  task automatic writeCmd(input logic [7:0] d);
    @(negedge clk);
    ioSel = 1; ioWr = 1; ioAddr = 2'd1; ioWdata = d;
    @(posedge clk);
    @(negedge clk);
    ioSel = 0; ioWr = 0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    ioSel = 1; ioRd = 1; ioAddr = a;
    #1 d = ioRdata;
    @(posedge clk);
    @(negedge clk);
    ioSel = 0; ioRd = 0;
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expectTaken);
    @(negedge clk);
    devByteValid = 1; devByte = b;
    if (expectTaken) expQ.push_back(b);
    @(posedge clk);
    @(negedge clk);
    devByteValid = 0;
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    // R1 reset state
    check("R1 dmaReq", {7'b0, dmaReq}, 8'h00);
    check("R1 devStart", {7'b0, devStart}, 8'h00);
    readReg(2'd0, r); check("R1 status", r, 8'h00);

    // start an input block
    devRemain = 16'd5;
    writeCmd(8'h05);
    check("R3 start pulse high", {7'b0, devStart}, 8'h01);
    @(negedge clk);
    check("R3 start pulse ends", {7'b0, devStart}, 8'h00);
    check("R2 devDirIn", {7'b0, devDirIn}, 8'h01);
    readReg(2'd1, r); check("R2 R3 command readback", r, 8'h01);
    readReg(2'd0, r); check("R4 busy", r, 8'h04);

    // R6 scoreboard traffic
    monEn = 1;
    sendByte(8'hA5, 1); repeat (3) @(negedge clk);
    sendByte(8'h3C, 1); repeat (3) @(negedge clk);
    sendByte(8'hFF, 1); repeat (3) @(negedge clk);
    monEn = 0;
    check("R6 queue drained", 8'(expQ.size()), 8'h00);

    // R7 request held until acknowledge
    sendByte(8'h5A, 0);
    repeat (3) @(negedge clk);
    check("R7 request held", {7'b0, dmaReq}, 8'h01);
    check("R7 data", dmaData, 8'h5A);
    manAck = 1;
    @(posedge clk);
    @(negedge clk) manAck = 0;
    check("R7 request dropped", {7'b0, dmaReq}, 8'h00);

    // R9 overrun, R8 buffer read, R12 pending bit
    sendByte(8'h11, 0);
    sendByte(8'h22, 0);
    readReg(2'd0, r); check("R9 R12 status overrun+pending", r, 8'h15);
    readReg(2'd2, r); check("R8 R9 buffer keeps first byte", r, 8'h11);
    check("R8 request cleared by read", {7'b0, dmaReq}, 8'h00);
    readReg(2'd0, r); check("R12 pending cleared", r, 8'h14);

    // R5 end of block
    devRemain = 16'd0;
    @(negedge clk);
    readReg(2'd0, r); check("R5 busy cleared", r, 8'h10);

    // R11 byte while idle
    sendByte(8'h77, 0);
    check("R11 idle byte no request", {7'b0, dmaReq}, 8'h00);
    readReg(2'd0, r); check("R11 idle status", r, 8'h10);

    // R10 restart in output direction
    devRemain = 16'd3;
    writeCmd(8'h04);
    readReg(2'd0, r); check("R10 overrun cleared, R4 busy", r, 8'h04);
    check("R2 direction output", {7'b0, devDirIn}, 8'h00);
    sendByte(8'h88, 0);
    check("R11 output-direction byte ignored", {7'b0, dmaReq}, 8'h00);
    readReg(2'd0, r); check("R11 status unchanged", r, 8'h04);
    readReg(2'd2, r); check("R11 buffer unchanged", r, 8'h11);

    finishRun();
  end
endmodule